// File: doc/BRIEF.md
# Linked-Descriptor Word-Copy Engine

This block is the transfer engine behind a single DMA channel. A register front-end hands it a descriptor address and a one-cycle start pulse. The engine then reads a six-word descriptor from memory and carries out the word copy that the descriptor describes. It then loads the descriptor's link word as its new descriptor pointer and repeats. It stops when that pointer is zero or when the channel enable has been withdrawn.

A copy is either linear, with one run of bytes, or two-dimensional. A two-dimensional copy has several rows of equal length, and separate signed row strides for the source and the destination. Each side has its own increment control and its own ignore control. An ignored source supplies zeros without any read. An ignored destination swallows the data without any write. All memory traffic goes through one word-wide master port with a request/grant handshake and a separate read-data-valid strobe. Only one access is in flight at a time.

The working copy of every descriptor field is exposed live, so the front-end can show it. This includes the remaining length, which is rewritten after every word. The front-end also receives a one-cycle end-of-block pulse and a one-cycle interrupt request.

Top module: `cbdma_engine`

## Requirements
- R1: On an accepted start, the engine reads six words at the descriptor address plus 0, 4, 8, 12, 16 and 20. In that order, it stores them as the info, source, destination, length, stride and link fields, and each appears on its `cur*` output.
- R2: A linear copy (info bit 1 clear) moves floor(length/4) words. The word read at each source address is written unchanged to the matching destination address.
- R3: After each word, the source address grows by 4 only if info bit 8 is set, and the destination address grows by 4 only if info bit 4 is set. Info bits 3, 5, 6, 9 and 10 have no effect on the copy.
- R4: With info bit 11 set, no source read is issued and zero is written instead. With info bit 7 set, no destination write is issued.
- R5: In 2D mode (info bit 1 set), the copy has length[29:16]+1 rows of length[15:0] bytes each. After every row except the last, the signed stride[15:0] is added to the source address and the signed stride[31:16] is added to the destination address.
- R6: After each word, the length output shows the bytes left in the current row. In 2D mode, the upper half shows the rows remaining including the current one, and the lower half shows the bytes left. Before the first word, the length output holds the fetched value.
- R7: A row ends as soon as fewer than 4 bytes remain, so a byte count that is not a multiple of 4 leaves the remainder (0 to 3) on the length output and never wraps.
- R8: Each finished descriptor produces exactly one `blockEnd` pulse. `irqReq` pulses together with it only if info bit 0 is set. In the following cycle, `curBlock` holds the link word.
- R9: The engine follows link words until it reaches a zero link, then drops `busy` and issues no further requests. After reset, `busy`, `memReq` and `curBlock` are zero.
- R10: A start while `chanEn` is low, or with a zero descriptor address, does nothing. Clearing `chanEn` during a chain stops the engine after the current descriptor, before the next fetch.
- R11: A request stays asserted with a stable address and direction until it is granted. No new request is made while a read awaits its data, and each write carries the data of the read that precedes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start pulse from the front-end |
| chanEn | input | 1 | Channel enable, checked at start and before every fetch |
| blockAddrIn | input | AW | First descriptor address, taken on start |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Byte address of the access |
| memWdata | output | 32 | Write data |
| memGnt | input | 1 | Request accepted this cycle |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |
| busy | output | 1 | Engine is working |
| blockEnd | output | 1 | Descriptor finished (one cycle) |
| irqReq | output | 1 | Interrupt request (one cycle) |
| curBlock | output | AW | Current descriptor pointer |
| curInfo | output | 32 | Live info field |
| curSrc | output | AW | Live source address |
| curDst | output | AW | Live destination address |
| curLen | output | 32 | Live remaining length |
| curStride | output | 32 | Fetched stride word |
| curNext | output | AW | Fetched link word |

## Verification
The bench sweeps every combination of the two increment bits, the two ignore bits and the mode, over zero, short, odd and multi-row lengths. It compares memory, access counts, final addresses and the final length against an arithmetic model. A design that applied the stride after the last row, or used the wrong stride half, would end with the wrong final addresses. A design that wrapped on an odd byte count would run away and trip the timeout. A design that read an ignored source would show extra reads and non-zero data. Chained, disabled, zero-pointer and mid-chain-disable runs catch an engine that checks the enable only once, or that loads the wrong link.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;
  localparam int WORD_W   = 32;
  localparam int CB_WORDS = 6;
  localparam int IDX_W    = $clog2(CB_WORDS);
  localparam int ROWS_W   = 15;

  typedef enum logic [1:0] {ADDR_CB, ADDR_SRC, ADDR_DST} addr_sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_SETUP, S_WORD,
    S_RREQ, S_RWAIT, S_WREQ, S_ROW, S_BEND
  } state_e;

  typedef struct packed {
    logic             loadPtr;
    logic             capWord;
    logic [IDX_W-1:0] wordIdx;
    logic             setupBlk;
    logic             takeRead;
    logic             takeZero;
    logic             stepWord;
    logic             nextRow;
    logic             advBlock;
    addr_sel_e        addrSel;
  } strobe_t;

  typedef struct packed {
    logic hasWord;
    logic moreRows;
    logic srcIgn;
    logic dstIgn;
    logic intEn;
    logic nextZero;
    logic entryZero;
  } status_t;
endpackage

// File: rtl/cbdma_ctrl.sv
module cbdma_ctrl
  import cbdma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    chanEn,
  input  status_t st,
  input  logic    memGnt,
  input  logic    memRvalid,
  output strobe_t stb,
  output logic    memReq,
  output logic    memWe,
  output logic    blockEnd,
  output logic    irqReq,
  output logic    busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CB_WORDS - 1);

  state_e state, nextState;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      state <= nextState;
      if (stb.loadPtr || stb.advBlock) idx <= '0;
      else if (stb.capWord)            idx <= idx + 1'b1;
    end
  end

  always_comb begin
    stb         = '0;
    stb.wordIdx = idx;
    stb.addrSel = ADDR_CB;
    memReq      = 1'b0;
    memWe       = 1'b0;
    blockEnd    = 1'b0;
    irqReq      = 1'b0;
    nextState   = state;
    unique case (state)
      S_IDLE: begin
        if (start && chanEn && !st.entryZero) begin
          stb.loadPtr = 1'b1;
          nextState   = S_FREQ;
        end
      end
      S_FREQ: begin
        memReq = 1'b1;
        if (memGnt) nextState = S_FWAIT;
      end
      S_FWAIT: begin
        if (memRvalid) begin
          stb.capWord = 1'b1;
          nextState   = (idx == LAST_IDX) ? S_SETUP : S_FREQ;
        end
      end
      S_SETUP: begin
        stb.setupBlk = 1'b1;
        nextState    = S_WORD;
      end
      S_WORD: begin
        if (!st.hasWord) begin
          nextState = S_ROW;
        end else if (st.srcIgn) begin
          stb.takeZero = 1'b1;
          nextState    = S_WREQ;
        end else begin
          nextState = S_RREQ;
        end
      end
      S_RREQ: begin
        stb.addrSel = ADDR_SRC;
        memReq      = 1'b1;
        if (memGnt) nextState = S_RWAIT;
      end
      S_RWAIT: begin
        if (memRvalid) begin
          stb.takeRead = 1'b1;
          nextState    = S_WREQ;
        end
      end
      S_WREQ: begin
        stb.addrSel = ADDR_DST;
        if (st.dstIgn) begin
          stb.stepWord = 1'b1;
          nextState    = S_WORD;
        end else begin
          memReq = 1'b1;
          memWe  = 1'b1;
          if (memGnt) begin
            stb.stepWord = 1'b1;
            nextState    = S_WORD;
          end
        end
      end
      S_ROW: begin
        if (st.moreRows) begin
          stb.nextRow = 1'b1;
          nextState   = S_WORD;
        end else begin
          nextState = S_BEND;
        end
      end
      S_BEND: begin
        stb.advBlock = 1'b1;
        blockEnd     = 1'b1;
        irqReq       = st.intEn;
        nextState    = (chanEn && !st.nextZero) ? S_FREQ : S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/cbdma_datapath.sv
module cbdma_datapath
  import cbdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [AW-1:0]     blockAddrIn,
  input  logic [WORD_W-1:0] memRdata,
  output logic [AW-1:0]     memAddr,
  output logic [WORD_W-1:0] memWdata,
  output status_t           st,
  output logic [AW-1:0]     curBlock,
  output logic [WORD_W-1:0] curInfo,
  output logic [AW-1:0]     curSrc,
  output logic [AW-1:0]     curDst,
  output logic [WORD_W-1:0] curLen,
  output logic [WORD_W-1:0] curStride,
  output logic [AW-1:0]     curNext
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] bytesLeft, rowBytes, dataReg, nextBytes;
  logic [ROWS_W-1:0] rowsLeft;
  logic [AW-1:0]     srcStr, dstStr;
  logic              twoD;

  assign twoD      = curInfo[1];
  assign nextBytes = bytesLeft - WORD_W'(4);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBlock  <= '0;
      curInfo   <= '0;
      curSrc    <= '0;
      curDst    <= '0;
      curLen    <= '0;
      curStride <= '0;
      curNext   <= '0;
      bytesLeft <= '0;
      rowBytes  <= '0;
      rowsLeft  <= '0;
      srcStr    <= '0;
      dstStr    <= '0;
      dataReg   <= '0;
    end else begin
      if (stb.loadPtr)  curBlock <= blockAddrIn;
      if (stb.advBlock) curBlock <= curNext;
      if (stb.capWord) begin
        unique case (stb.wordIdx)
          IDX_W'(0): curInfo   <= memRdata;
          IDX_W'(1): curSrc    <= memRdata[AW-1:0];
          IDX_W'(2): curDst    <= memRdata[AW-1:0];
          IDX_W'(3): curLen    <= memRdata;
          IDX_W'(4): curStride <= memRdata;
          default:   curNext   <= memRdata[AW-1:0];
        endcase
      end
      if (stb.setupBlk) begin
        if (twoD) begin
          rowsLeft  <= ROWS_W'({1'b0, curLen[29:16]}) + 1'b1;
          rowBytes  <= WORD_W'(curLen[HALF_W-1:0]);
          bytesLeft <= WORD_W'(curLen[HALF_W-1:0]);
          srcStr    <= AW'($signed(curStride[HALF_W-1:0]));
          dstStr    <= AW'($signed(curStride[WORD_W-1:HALF_W]));
        end else begin
          rowsLeft  <= ROWS_W'(1);
          rowBytes  <= curLen;
          bytesLeft <= curLen;
          srcStr    <= '0;
          dstStr    <= '0;
        end
      end
      if (stb.takeRead) dataReg <= memRdata;
      if (stb.takeZero) dataReg <= '0;
      if (stb.stepWord) begin
        bytesLeft <= nextBytes;
        if (curInfo[8]) curSrc <= curSrc + AW'(4);
        if (curInfo[4]) curDst <= curDst + AW'(4);
        curLen <= twoD ? {HALF_W'(rowsLeft), nextBytes[HALF_W-1:0]} : nextBytes;
      end
      if (stb.nextRow) begin
        curSrc    <= curSrc + srcStr;
        curDst    <= curDst + dstStr;
        bytesLeft <= rowBytes;
        rowsLeft  <= rowsLeft - 1'b1;
      end
    end
  end

  always_comb begin
    unique case (stb.addrSel)
      ADDR_SRC: memAddr = curSrc;
      ADDR_DST: memAddr = curDst;
      default:  memAddr = curBlock + AW'({stb.wordIdx, 2'b00});
    endcase
  end

  assign memWdata     = dataReg;
  assign st.hasWord   = (bytesLeft >= WORD_W'(4));
  assign st.moreRows  = (rowsLeft > ROWS_W'(1));
  assign st.srcIgn    = curInfo[11];
  assign st.dstIgn    = curInfo[7];
  assign st.intEn     = curInfo[0];
  assign st.nextZero  = (curNext == '0);
  assign st.entryZero = (blockAddrIn == '0);
endmodule

// File: rtl/cbdma_engine.sv
module cbdma_engine
  import cbdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              chanEn,
  input  logic [AW-1:0]     blockAddrIn,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memGnt,
  input  logic              memRvalid,
  input  logic [WORD_W-1:0] memRdata,
  output logic              busy,
  output logic              blockEnd,
  output logic              irqReq,
  output logic [AW-1:0]     curBlock,
  output logic [WORD_W-1:0] curInfo,
  output logic [AW-1:0]     curSrc,
  output logic [AW-1:0]     curDst,
  output logic [WORD_W-1:0] curLen,
  output logic [WORD_W-1:0] curStride,
  output logic [AW-1:0]     curNext
);
  strobe_t stb;
  status_t st;

  cbdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .chanEn(chanEn), .st(st),
    .memGnt(memGnt), .memRvalid(memRvalid), .stb(stb), .memReq(memReq),
    .memWe(memWe), .blockEnd(blockEnd), .irqReq(irqReq), .busy(busy)
  );

  cbdma_datapath #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .blockAddrIn(blockAddrIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .st(st),
    .curBlock(curBlock), .curInfo(curInfo), .curSrc(curSrc), .curDst(curDst),
    .curLen(curLen), .curStride(curStride), .curNext(curNext)
  );
endmodule

// File: rtl/cbdma_chk.sv
module cbdma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          chanEn,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          memGnt,
  input logic          memRvalid,
  input logic          busy,
  input logic          blockEnd,
  input logic          irqReq,
  input logic [AW-1:0] curBlock,
  input logic [31:0]   curInfo,
  input logic [AW-1:0] curNext
);
  logic pendRd;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendRd <= 1'b0;
    else if (memReq && !memWe && memGnt) pendRd <= 1'b1;
    else if (memRvalid) pendRd <= 1'b0;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe));
  // R11
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendRd |-> !memReq);
  // R4
  dst_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !curInfo[7]);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> blockEnd && curInfo[0]);
  // R8
  link_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockEnd |=> curBlock == $past(curNext));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !blockEnd);
  // R10
  disabled_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && !chanEn |=> !busy);
endmodule

bind cbdma_engine cbdma_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_cbdma_engine.sv
module test_cbdma_engine;
  localparam int AW    = 32;
  localparam int MEM_N = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic chanEn = 1'b1;
  logic [AW-1:0] blockAddrIn = '0;
  logic memReq, memWe, memGnt, busy, blockEnd, irqReq;
  logic memRvalid = 1'b0;
  logic [31:0] memRdata = '0;
  logic [AW-1:0] memAddr, curBlock, curSrc, curDst, curNext;
  logic [31:0] memWdata, curInfo, curLen, curStride;

  always #2 clk = ~clk;

  cbdma_engine #(.AW(AW)) i_cbdma_engine (
    .clk(clk), .rstN(rstN), .start(start), .chanEn(chanEn),
    .blockAddrIn(blockAddrIn), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memGnt(memGnt),
    .memRvalid(memRvalid), .memRdata(memRdata), .busy(busy),
    .blockEnd(blockEnd), .irqReq(irqReq), .curBlock(curBlock),
    .curInfo(curInfo), .curSrc(curSrc), .curDst(curDst), .curLen(curLen),
    .curStride(curStride), .curNext(curNext)
  );

  logic [31:0] mem    [0:MEM_N-1];
  logic [31:0] refMem [0:MEM_N-1];
  logic [15:0] lfsr = 16'hACE1;
  logic        rdPend = 1'b0;
  logic [1:0]  rdLat = '0;
  logic [31:0] rdBuf = '0;

  assign memGnt = memReq & lfsr[0];

  always @(posedge clk) begin
    lfsr <= {lfsr[0], lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    memRvalid <= 1'b0;
    if (rdPend) begin
      if (rdLat == 2'd0) begin
        memRvalid <= 1'b1;
        memRdata  <= rdBuf;
        rdPend    <= 1'b0;
      end else rdLat <= rdLat - 2'd1;
    end
    if (memReq && memGnt) begin
      if (memWe) mem[memAddr[12:2]] <= memWdata;
      else begin
        rdPend <= 1'b1;
        rdLat  <= lfsr[2:1];
        rdBuf  <= mem[memAddr[12:2]];
      end
    end
  end

  int rdCnt, wrCnt, endCnt, irqCnt;
  logic [31:0] fetchLog [0:5];
  always @(posedge clk) begin
    if (rstN) begin
      if (memReq && memGnt && !memWe) begin
        if (rdCnt < 6) fetchLog[rdCnt] = memAddr;
        rdCnt++;
      end
      if (memReq && memGnt && memWe) wrCnt++;
      if (blockEnd) endCnt++;
      if (irqReq) irqCnt++;
    end
  end

  int nChecks = 0;
  int nFails  = 0;
  int runId   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s run %0d: actual %h expected %h", req, what, runId, act, exp);
    end
  endtask

  task automatic putCB(input logic [31:0] a, input logic [31:0] info, src, dst, len, stride, nxt);
    mem[a[12:2]]   = info;  refMem[a[12:2]]   = info;
    mem[a[12:2]+1] = src;   refMem[a[12:2]+1] = src;
    mem[a[12:2]+2] = dst;   refMem[a[12:2]+2] = dst;
    mem[a[12:2]+3] = len;   refMem[a[12:2]+3] = len;
    mem[a[12:2]+4] = stride; refMem[a[12:2]+4] = stride;
    mem[a[12:2]+5] = nxt;   refMem[a[12:2]+5] = nxt;
  endtask

  task automatic fillRegions();
    for (int i = 'h100; i < 'h300; i++) begin
      logic [31:0] v;
      v = (i < 'h200) ? {runId[7:0], 24'(i * 7 + 1)} : {8'hDD, 16'h0, runId[7:0]};
      mem[i] = v;
      refMem[i] = v;
    end
  endtask

  // Arithmetic reference for one descriptor (R2-R7)
  task automatic modelBlock(input logic [31:0] info, src, dst, len, stride,
                            output logic [31:0] fSrc, fDst, fLen, output int nRd, nWr);
    int rows;
    logic [31:0] rb, b, s, d, ss, ds, v;
    rows = info[1] ? int'(len[29:16]) + 1 : 1;
    rb   = info[1] ? {16'h0, len[15:0]} : len;
    ss   = info[1] ? {{16{stride[15]}}, stride[15:0]} : 32'h0;
    ds   = info[1] ? {{16{stride[31]}}, stride[31:16]} : 32'h0;
    s = src; d = dst; fLen = len; nRd = 0; nWr = 0;
    for (int r = 0; r < rows; r++) begin
      b = rb;
      while (b >= 4) begin
        if (info[11]) v = 32'h0;
        else begin v = refMem[s[12:2]]; nRd++; end
        if (!info[7]) begin refMem[d[12:2]] = v; nWr++; end
        if (info[8]) s += 4;
        if (info[4]) d += 4;
        b -= 4;
        fLen = info[1] ? {16'(rows - r), b[15:0]} : b;
      end
      if (r != rows - 1) begin s += ss; d += ds; end
    end
    fSrc = s; fDst = d;
  endtask

  task automatic clearCounts();
    rdCnt = 0; wrCnt = 0; endCnt = 0; irqCnt = 0;
  endtask

  task automatic kick(input logic [31:0] cb);
    @(negedge clk);
    blockAddrIn = cb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R9", "engine returns to idle", 32'(t), 32'd0);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmpDst(input string req);
    int bad = 0;
    for (int i = 'h200; i < 'h300; i++) if (mem[i] !== refMem[i]) bad++;
    chk(bad == 0, req, "destination image mismatches", 32'(bad), 32'd0);
  endtask

  task automatic runOne(input logic [31:0] info, src, dst, len, stride);
    logic [31:0] fS, fD, fL;
    int nR, nW;
    runId++;
    fillRegions();
    putCB(32'h100, info, src, dst, len, stride, 32'h0);
    modelBlock(info, src, dst, len, stride, fS, fD, fL, nR, nW);
    clearCounts();
    kick(32'h100);
    waitIdle();
    for (int k = 0; k < 6; k++)
      chk(fetchLog[k] == 32'h100 + 32'(4 * k), "R1", "descriptor fetch address", fetchLog[k], 32'h100 + 32'(4 * k));
    chk(curInfo == info && curStride == stride, "R1", "fetched info", curInfo, info);
    cmpDst("R2 R4 R5");
    chk(rdCnt == 6 + nR, "R4", "read count", 32'(rdCnt), 32'(6 + nR));
    chk(wrCnt == nW, "R4", "write count", 32'(wrCnt), 32'(nW));
    chk(curSrc == fS, "R3 R5", "final source address", curSrc, fS);
    chk(curDst == fD, "R3 R5", "final destination address", curDst, fD);
    chk(curLen == fL, "R6 R7", "final remaining length", curLen, fL);
    chk(endCnt == 1, "R8", "end pulses", 32'(endCnt), 32'd1);
    chk(irqCnt == (info[0] ? 1 : 0), "R8", "interrupt pulses", 32'(irqCnt), {31'd0, info[0]});
    chk(curBlock == 32'h0, "R9", "pointer after zero link", curBlock, 32'h0);
  endtask

  initial begin
    #(200000 * 4 - 100);
    nChecks++; nFails++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] fS, fD, fL;
    int nR, nW;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && memReq == 1'b0, "R9", "reset busy/request", {busy, memReq}, 32'd0);
    chk(curBlock == 32'h0, "R9", "reset pointer", curBlock, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep: increments, ignores, mode, lengths (R2-R7)
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int ls = 0; ls < 3; ls++) begin
        logic [31:0] info, len;
        info = 32'h0;
        info[8]  = cfg[0];
        info[4]  = cfg[1];
        info[11] = cfg[2];
        info[7]  = cfg[3];
        info[1]  = cfg[4];
        info[0]  = cfg[0] ^ cfg[3] ^ ls[0];
        if (cfg[0] ^ cfg[2]) info = info | 32'h0000_0668; // R3 inert bits
        if (cfg[4]) len = (ls == 0) ? 32'h0000_0008 : (ls == 1) ? 32'h0002_000C : 32'h0001_0006;
        else        len = (ls == 0) ? 32'h0 : (ls == 1) ? 32'd10 : 32'd16;
        runOne(info, 32'h500, 32'h900, len, 32'h0014_FFF8);
      end
    end

    // Chain of three descriptors (R8, R9)
    runId++;
    fillRegions();
    putCB(32'h100, 32'h0000_0111, 32'h400, 32'h800, 32'd8, 32'h0, 32'h120);
    putCB(32'h120, 32'h0000_0110, 32'h440, 32'h840, 32'd12, 32'h0, 32'h140);
    putCB(32'h140, 32'h0000_0111, 32'h480, 32'h880, 32'd4, 32'h0, 32'h0);
    modelBlock(32'h111, 32'h400, 32'h800, 32'd8, 32'h0, fS, fD, fL, nR, nW);
    modelBlock(32'h110, 32'h440, 32'h840, 32'd12, 32'h0, fS, fD, fL, nR, nW);
    modelBlock(32'h111, 32'h480, 32'h880, 32'd4, 32'h0, fS, fD, fL, nR, nW);
    clearCounts();
    kick(32'h100);
    waitIdle();
    cmpDst("R9 chain");
    chk(endCnt == 3, "R8", "chain end pulses", 32'(endCnt), 32'd3);
    chk(irqCnt == 2, "R8", "chain interrupt pulses", 32'(irqCnt), 32'd2);
    chk(curBlock == 32'h0, "R9", "chain final pointer", curBlock, 32'h0);

    // Start with channel disabled (R10)
    runId++;
    clearCounts();
    chanEn = 1'b0;
    kick(32'h100);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && rdCnt == 0, "R10", "disabled start ignored", 32'(rdCnt), 32'd0);
    chanEn = 1'b1;

    // Start with zero pointer (R10)
    runId++;
    clearCounts();
    kick(32'h0);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && rdCnt == 0, "R10", "zero pointer start ignored", 32'(rdCnt), 32'd0);

    // Enable withdrawn mid-chain (R10)
    runId++;
    fillRegions();
    putCB(32'h100, 32'h0000_0110, 32'h400, 32'h800, 32'd8, 32'h0, 32'h120);
    putCB(32'h120, 32'h0000_0110, 32'h440, 32'h840, 32'd8, 32'h0, 32'h0);
    modelBlock(32'h110, 32'h400, 32'h800, 32'd8, 32'h0, fS, fD, fL, nR, nW);
    clearCounts();
    kick(32'h100);
    repeat (3) @(negedge clk);
    chanEn = 1'b0;
    waitIdle();
    cmpDst("R10 stop");
    chk(endCnt == 1, "R10", "blocks done after disable", 32'(endCnt), 32'd1);
    chk(curBlock == 32'h120, "R10", "pointer left at link", curBlock, 32'h120);
    chanEn = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule